// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a bitstream into a downstream FPGA over a slave-serial style link. It drives four lines toward the target: an active-low program/reset line, a configuration clock, a serial data line and a post-configuration flag. A one-cycle start pulse latches a byte count. The block then pulls every line low to hold the target in reset, raises the program line and waits so the target can clear its configuration memory. Only then does it shift the bytes out.

Bytes come in on a valid/ready stream. Each byte goes out least-significant bit first. Every bit gets a clock-low phase that presents the data, then a clock-high phase that keeps the same data. The target samples on the rising edge. When the last bit is done, the outputs settle on a fixed end word in which only the post-configuration flag is high. A one-cycle done pulse marks the end of the load.

Both waits are derived from the system clock frequency and a delay length in microseconds, rounded up to whole cycles. Each clock phase lasts a set number of system cycles.

Top module: `cfg_loader`

## Requirements
- R1: While rst_n is low, and after it is released, prog_b, cfg_clk, cfg_dout, post_flag, busy, done and in_ready are all 0.
- R2: A start pulse while idle drives prog_b, cfg_clk, cfg_dout and post_flag low. They stay low for at least DLY cycles, where DLY = ceil(CLK_FREQ_HZ * DELAY_US / 1e6).
- R3: After the reset interval, prog_b goes high and stays high for at least DLY cycles before the first rising edge of cfg_clk.
- R4: prog_b never falls between its release and the done pulse.
- R5: Bytes go out in arrival order, eight bits per byte, bit 0 first. The bit sampled on the k-th rising edge of cfg_clk is bit (k mod 8) of byte (k div 8).
- R6: Each bit is presented on cfg_dout with cfg_clk low for at least PHASE_CYC cycles. cfg_clk is then high for at least PHASE_CYC cycles, and cfg_dout does not change while cfg_clk rises.
- R7: When the load ends, post_flag is 1 and prog_b, cfg_clk and cfg_dout are 0. done is high for exactly one cycle, and busy is low from that cycle on.
- R8: in_ready is high only while the block waits for a byte. While it waits, cfg_clk is low and prog_b is high, and an absent byte stalls the link in that state.
- R9: busy is high from the cycle after an accepted start until done. A start pulse while busy has no effect on the byte count, the bit stream or the done count.
- R10: A byte count of 0 skips the data phase. The reset interval, settle interval and end word are still produced, with no edge on cfg_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle load request |
| byte_count | input | CNT_W | Number of bytes in the load, latched on start |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block takes the byte on this edge |
| prog_b | output | 1 | Active-low program/reset line to the target |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| post_flag | output | 1 | Post-configuration flag, part of the end word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of a load |

## Verification
All link outputs are registered. The end word and done therefore appear one edge after the last clock-high phase expires. busy and in_ready follow the state register within the same cycle. The bench samples everything on the falling clock edge, half a cycle after the register updates. It measures the intervals as run lengths of those samples rather than predicting absolute cycle numbers: the reset run, the settle run before the first cfg_clk rise, and each clock-phase run. It polls done on falling edges, checks the end word in that same sample, and checks one sample later that done has dropped. Captured bits are compared with the sent bytes reordered bit 0 first. That comparison does not depend on the stall pattern that the random valid gaps produce.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int DELAY_US    = 100,
  parameter int PHASE_CYC   = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             prog_b,
  output logic             cfg_clk,
  output logic             cfg_dout,
  output logic             post_flag,
  output logic             busy,
  output logic             done
);

  localparam longint DLY_RAW = (longint'(CLK_FREQ_HZ) * DELAY_US + 999_999) / 1_000_000;
  localparam int DLY_CYC = (DLY_RAW < 1) ? 1 : int'(DLY_RAW);
  localparam int PH_CYC  = (PHASE_CYC < 1) ? 1 : PHASE_CYC;
  localparam int TMR_MAX = (DLY_CYC > PH_CYC) ? DLY_CYC : PH_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_SETTLE, S_FETCH, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] left;
  logic [7:0]       shreg;
  logic [2:0]       bitn;

  wire dly_end = (tmr == TMR_W'(DLY_CYC - 1));
  wire ph_end  = (tmr == TMR_W'(PH_CYC - 1));

  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      left      <= '0;
      shreg     <= '0;
      bitn      <= '0;
      prog_b    <= 1'b0;
      cfg_clk   <= 1'b0;
      cfg_dout  <= 1'b0;
      post_flag <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_RST;
          tmr       <= '0;
          left      <= byte_count;
          prog_b    <= 1'b0;
          cfg_clk   <= 1'b0;
          cfg_dout  <= 1'b0;
          post_flag <= 1'b0;
        end
        S_RST: if (dly_end) begin
          prog_b <= 1'b1;
          tmr    <= '0;
          st     <= S_SETTLE;
        end else tmr <= tmr + 1'b1;
        S_SETTLE: if (dly_end) begin
          tmr <= '0;
          if (left == '0) begin
            st        <= S_IDLE;
            prog_b    <= 1'b0;
            cfg_dout  <= 1'b0;
            post_flag <= 1'b1;
            done      <= 1'b1;
          end else st <= S_FETCH;
        end else tmr <= tmr + 1'b1;
        S_FETCH: if (in_valid) begin
          shreg    <= in_data;
          cfg_dout <= in_data[0];
          bitn     <= '0;
          tmr      <= '0;
          st       <= S_LOW;
        end
        S_LOW: if (ph_end) begin
          cfg_clk <= 1'b1;
          tmr     <= '0;
          st      <= S_HIGH;
        end else tmr <= tmr + 1'b1;
        S_HIGH: if (ph_end) begin
          cfg_clk <= 1'b0;
          tmr     <= '0;
          if (bitn == 3'd7) begin
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
              st        <= S_IDLE;
              prog_b    <= 1'b0;
              cfg_dout  <= 1'b0;
              post_flag <= 1'b1;
              done      <= 1'b1;
            end else st <= S_FETCH;
          end else begin
            bitn     <= bitn + 1'b1;
            shreg    <= shreg >> 1;
            cfg_dout <= shreg[1];
            st       <= S_LOW;
          end
        end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RST) |-> (!prog_b && !cfg_clk && !cfg_dout && !post_flag)); // R2
  AST_NO_CLK_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> (prog_b && !cfg_clk)); // R3
  AST_PROG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH || st == S_LOW || st == S_HIGH) |-> prog_b); // R4
  AST_DATA_STEADY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_dout)); // R6
  AST_END_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (post_flag && !prog_b && !cfg_clk && !cfg_dout && !busy)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_STALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!cfg_clk && prog_b)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (left == $past(left) || $past(st) == S_HIGH)); // R9

endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int FREQ = 125_000_000;
  localparam int DUS  = 2;
  localparam int PH   = 3;
  localparam int CW   = 16;
  localparam int DLY  = (FREQ / 1000 * DUS + 999) / 1000;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] in_data = '0;
  logic in_ready, prog_b, cfg_clk, cfg_dout, post_flag, busy, done;

  cfg_loader #(.CLK_FREQ_HZ(FREQ), .DELAY_US(DUS), .PHASE_CYC(PH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .prog_b(prog_b), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .post_flag(post_flag),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] bytes [0:63];
  logic cap [0:511];
  int cap_n, rst_lo, settle, prog_drop, done_n, stall_bad, ph_bad, run;
  logic prev_clk, prev_prog, seen_rise, monitor_on;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (monitor_on) begin
      if (cfg_clk && !prev_clk && prog_b && cap_n < 512) begin cap[cap_n] = cfg_dout; cap_n++; end
      if (busy && !prog_b) rst_lo++;
      if (busy && prog_b && !seen_rise) settle++;
      if (prev_prog && !prog_b && busy) prog_drop++;
      if (done) done_n++;
      if (in_ready && (cfg_clk || !prog_b)) stall_bad++;
      if (cfg_clk != prev_clk) begin
        if (prev_clk && run < PH) ph_bad++;
        if (!prev_clk && seen_rise && run < PH) ph_bad++;
        if (cfg_clk) seen_rise = 1;
        run = 1;
      end else run++;
    end
    prev_clk = cfg_clk;
    prev_prog = prog_b;
  end

  task automatic feed(input int n);
    int idx = 0;
    bit pend = 0;
    while (idx < n) begin
      @(negedge clk);
      if (pend) idx++;
      pend = 0;
      if (idx < n) begin
        in_valid = ($urandom % 4) != 0;
        in_data = in_valid ? bytes[idx] : 8'($urandom);
        pend = in_valid && in_ready;
      end else in_valid = 0;
    end
  endtask

  task automatic run_load(input int n, input bit poke);
    int bad = 0;
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    @(negedge clk);
    cap_n = 0; rst_lo = 0; settle = 0; prog_drop = 0; done_n = 0;
    stall_bad = 0; ph_bad = 0; run = 0; seen_rise = 0; monitor_on = 1;
    start = 1; byte_count = CW'(n);
    fork feed(n); join_none
    @(negedge clk);
    start = 0; byte_count = CW'($urandom % 40);
    chk(busy == 1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (DLY + 20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk(post_flag && !prog_b && !cfg_clk && !cfg_dout, "R7", "end word {prog,clk,dat,post}",
        {prog_b, cfg_clk, cfg_dout, post_flag}, 4'b0001);
    chk(busy == 0, "R7", "busy at done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R7", "done width", done, 0);
    chk(done_n == 1, poke ? "R9" : "R7", "done pulses", done_n, 1);
    chk(cap_n == n * 8, n == 0 ? "R10" : "R5", "captured bit count", cap_n, n * 8);
    for (int k = 0; k < n * 8 && k < cap_n; k++)
      if (cap[k] !== bytes[k / 8][k % 8]) bad++;
    chk(bad == 0, "R5", "LSB-first bit mismatches", bad, 0);
    chk(rst_lo >= DLY, "R2", "reset low cycles", rst_lo, DLY);
    chk(settle >= DLY, "R3", "settle cycles", settle, DLY);
    chk(prog_drop == 0, "R4", "prog drops during upload", prog_drop, 0);
    chk(ph_bad == 0, "R6", "short clock phases", ph_bad, 0);
    chk(stall_bad == 0, "R8", "ready with clk high or prog low", stall_bad, 0);
    monitor_on = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !in_ready && post_flag, "R8", "idle after load", {busy, in_ready, post_flag}, 3'b001);
  endtask

  initial begin
    void'($urandom(32'd1234));
    monitor_on = 0; prev_clk = 0; prev_prog = 0; seen_rise = 0;
    repeat (3) @(negedge clk);
    chk({prog_b, cfg_clk, cfg_dout, post_flag, busy, done, in_ready} == 7'b0, "R1",
        "outputs in reset", {prog_b, cfg_clk, cfg_dout, post_flag, busy, done, in_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({prog_b, cfg_clk, cfg_dout, post_flag, busy, done, in_ready} == 7'b0, "R1",
        "outputs after reset", {prog_b, cfg_clk, cfg_dout, post_flag, busy, done, in_ready}, 0);
    run_load(0, 0);
    run_load(1, 0);
    run_load(5, 1);
    for (int t = 0; t < 18; t++) run_load(1 + int'($urandom % 16), t % 5 == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule